// File: doc/BRIEF.md
# Serial Two-Wire Memory Read Target

This block is an I2C target that fronts a 256-word by 8-bit register file and answers read requests. It samples the SCL and SDA lines from a fast system clock through a synchronizer and a three-sample majority filter. From the filtered lines it detects Start, repeated Start and Stop. It then takes in a control byte, optionally takes a word address, and shifts stored words back to the master. SDA is driven only as an open-drain pull-down.

The target keeps an address pointer that persists across transactions. It supports three read styles:
- **Current-address read:** a read control byte returns the word at the pointer.
- **Random read:** a write control byte and a word address load the pointer. A repeated Start then abandons the write, and a read control byte fetches the addressed word.
- **Sequential read:** each master acknowledge of a read byte streams the next word, wrapping from 255 to 0.

Writing into the array is not part of this block. The array is filled through a test preload port.

States of the byte engine:
- `ST_IDLE`: bus free.
- `ST_CTRL`: receiving the control byte.
- `ST_CTRL_ACK`: pulling SDA low for the control acknowledge.
- `ST_ADDR`: receiving the word address.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_HOLD`: write phase parked, waiting for Start or Stop.
- `ST_TX`: shifting a data word out.
- `ST_MACK`: sampling the master's acknowledge.
- `ST_IGNORE`: deaf until the next Start.

Transitions:
- Start from any state goes to `ST_CTRL`.
- Stop from any state goes to `ST_IDLE`.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a matching control byte, or to `ST_IGNORE` on a mismatch.
- `ST_CTRL_ACK` goes to `ST_TX` for a read, or to `ST_ADDR` for a write.
- `ST_ADDR` goes to `ST_ADDR_ACK`, and then to `ST_HOLD`.
- `ST_TX` goes to `ST_MACK` after eight bits.
- `ST_MACK` goes back to `ST_TX` on a master acknowledge, or to `ST_IGNORE` on a no-acknowledge.

Top module: `eeprom_rd_target`

## Requirements
- R1: A falling SDA while SCL is high (Start) restarts control-byte reception from any state, including partway through a byte. A rising SDA while SCL is high (Stop) returns the block to idle with SDA released.
- R2: A control byte whose bits 7:4 equal 1010 is acknowledged by pulling SDA low through the ninth clock. Bits 3:1 are ignored. Bit 0 is the direction, where 1 means read.
- R3: A control byte whose bits 7:4 differ from 1010 is not acknowledged. All following bytes are ignored until the next Start, and the pointer is left unchanged.
- R4: After a write control byte, the word address byte is acknowledged and loaded into the pointer. A following repeated Start or Stop ends the write without changing the array, and the pointer keeps the loaded address.
- R5: After a read control byte is acknowledged, the word at the pointer is sent most significant bit first, with each bit placed after a falling SCL edge.
- R6: The pointer advances by one after every word sent and wraps from 255 to 0. A current-address read after an access to address n returns the word at n+1.
- R7: A master acknowledge (SDA low on the ninth clock of a read byte) starts the next word. A no-acknowledge leaves SDA released until the next Start or Stop.
- R8: SDA is only ever pulled low, and the pull-down changes only while the filtered SCL is low. Reset leaves it released.
- R9: With the preload enable high, the preload data is written into the array at the preload address on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA to ground |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload word address |
| pre_data | input | 8 | Preload word value |

## Verification
The array is preloaded with the odd-multiplier sequence (37·a + 11) mod 256, so every address holds a distinct word. A shifted, bit-reversed or off-by-one read therefore shows up as a wrong value.

The main read path is tried in several ways:
- Random reads at scattered addresses separate pointer loading from pointer increment.
- Current-address reads after each other access show whether the pointer survived a Stop, a repeated Start, a rejected control byte or a Start in the middle of a byte.
- One streamed read of 257 words covers the entire array and the wrap from 255 to 0.
- Reads ended with a no-acknowledge, with the bus then held low, show whether the target lets go of SDA.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } state_t;

    localparam int unsigned BYTE_W   = 8;
    localparam logic [3:0]  CTRL_TAG = 4'b1010;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        IDLE_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   vote;

    assign vote = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= IDLE_VAL;
                else        sync_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_VAL}};
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= {3{IDLE_VAL}};
            dout   <= IDLE_VAL;
        end else begin
            hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
            dout   <= vote;
        end
    end
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_rd_target.sv
module eeprom_rd_target
    import i2c_rd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

    logic              scl_f, sda_f, scl_q, sda_q;
    logic              scl_rise, scl_fall, start_det, stop_det;
    state_t            st, st_n;
    logic [BYTE_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh, rd_data;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] ptr;
    logic              rw_q, mack_q;
    logic              byte_full, tx_done, ctrl_ok;

    line_filter #(.SYNC_STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f)
    );
    line_filter #(.SYNC_STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f)
    );

    word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(pre_we), .waddr(pre_addr), .wdata(pre_data),
        .raddr(ptr), .rdata(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
    assign tx_done   = (bit_cnt == CNT_W'(DATA_W));
    assign ctrl_ok   = (rx_sh[BYTE_W-1 -: 4] == CTRL_TAG);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Next-state logic
    always_comb begin
        st_n = st;
        if (start_det) begin
            st_n = ST_CTRL;
        end else if (stop_det) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE, ST_HOLD, ST_IGNORE: st_n = st;
                ST_CTRL:     if (scl_fall && byte_full) st_n = ctrl_ok ? ST_CTRL_ACK : ST_IGNORE;
                ST_CTRL_ACK: if (scl_fall) st_n = rw_q ? ST_TX : ST_ADDR;
                ST_ADDR:     if (scl_fall && byte_full) st_n = ST_ADDR_ACK;
                ST_ADDR_ACK: if (scl_fall) st_n = ST_HOLD;
                ST_TX:       if (scl_fall && tx_done) st_n = ST_MACK;
                ST_MACK:     if (scl_fall) st_n = mack_q ? ST_TX : ST_IGNORE;
                default:     st_n = ST_IDLE;
            endcase
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else begin
            unique case (st)
                ST_CTRL, ST_ADDR: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        bit_cnt <= '0;
                        if (st == ST_CTRL) begin
                            rw_q   <= rx_sh[0];
                            sda_oe <= ctrl_ok;
                        end else begin
                            ptr    <= rx_sh[ADDR_W-1:0];
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                ST_TX: begin
                    if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                    if (scl_fall) begin
                        if (tx_done) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            ptr     <= ptr + 1'b1;
                        end else begin
                            tx_sh  <= tx_sh << 1;
                            sda_oe <= ~tx_sh[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) mack_q <= ~sda_f;
                    if (scl_fall && mack_q) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_rd_checker.sv
module eeprom_rd_checker
    import i2c_rd_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_f,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_oe,
    input state_t        st,
    input logic [AW-1:0] ptr
);
    assert_start_to_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_CTRL));

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe));

    assert_ctrl_ack_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTRL_ACK) |-> sda_oe);

    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_TX && st == ST_MACK) |-> (ptr == AW'($past(ptr) + 1'b1)));

    assert_mack_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK) |-> !sda_oe);

    assert_oe_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
endmodule

bind eeprom_rd_target eeprom_rd_checker #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .st(st), .ptr(ptr)
);

// File: tb/eeprom_rd_target_tb.sv
module eeprom_rd_target_tb;
    localparam int CLK_NS  = 10;
    localparam int Q_CLK   = 10;
    localparam int WDOG_CY = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic       sda_line;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    eeprom_rd_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    function automatic logic [7:0] expw(input int a);
        return 8'(((a & 255) * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q_CLK);
        scl_m = 1'b1; wclk(Q_CLK);
        sda_m = 1'b0; wclk(Q_CLK);
        scl_m = 1'b0; wclk(Q_CLK);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q_CLK);
        scl_m = 1'b1; wclk(Q_CLK);
        sda_m = 1'b1; wclk(Q_CLK);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wclk(Q_CLK);
        scl_m = 1'b1; wclk(2*Q_CLK);
        scl_m = 1'b0; wclk(Q_CLK);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wclk(Q_CLK);
        scl_m = 1'b1; wclk(Q_CLK);
        acked = ~sda_line; wclk(Q_CLK);
        scl_m = 1'b0; wclk(Q_CLK);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wclk(Q_CLK);
            scl_m = 1'b1; wclk(Q_CLK);
            d = {d[6:0], sda_line}; wclk(Q_CLK);
            scl_m = 1'b0; wclk(Q_CLK);
        end
        put_bit(give_ack ? 1'b0 : 1'b1);
    endtask

    // write control byte plus word address, leaving the bus in the write phase
    task automatic set_addr(input int a);
        logic ak;
        bus_start();
        send_byte(8'hA0, ak); chk("R2 write control ack", int'(ak), 1);
        send_byte(8'(a), ak); chk("R4 word address ack", int'(ak), 1);
    endtask

    // (repeated) start, read control, n words, nack on the last, stop
    task automatic read_run(input logic [7:0] ctrl, input int first, input int n);
        logic ak;
        logic [7:0] d;
        bus_start();
        send_byte(ctrl, ak); chk("R2 read control ack", int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, d);
            chk("R5/R6/R7 read word", int'(d), int'(expw(first + i)));
        end
        wclk(3*Q_CLK);
        chk("R7 released after nack", int'(sda_oe), 0);
        bus_stop();
        wclk(2*Q_CLK);
        chk("R1 released after stop", int'(sda_oe), 0);
    endtask

    initial begin
        wclk(WDOG_CY);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ak;
        wclk(4);
        chk("R8 reset released", int'(sda_oe), 0);
        rst_n = 1'b1;
        wclk(4);

        // R9 preload whole array
        for (int a = 0; a < 256; a++) begin
            pre_we = 1'b1; pre_addr = 8'(a); pre_data = expw(a);
            wclk(1);
        end
        pre_we = 1'b0;
        wclk(10);
        chk("R8 idle released", int'(sda_oe), 0);

        // random read, then current-address read
        set_addr(8'h10);
        read_run(8'hA1, 8'h10, 1);
        read_run(8'hA1, 8'h11, 1);

        // sequential read across the top, then current read
        set_addr(8'hFC);
        read_run(8'hA1, 8'hFC, 8);
        read_run(8'hA1, 8'h04, 1);

        // R3 bad control: no ack, next byte ignored, pointer unchanged
        bus_start();
        send_byte(8'h5A, ak); chk("R3 bad control not acked", int'(ak), 0);
        send_byte(8'hA1, ak); chk("R3 ignored until start", int'(ak), 0);
        chk("R3 no drive while ignoring", int'(sda_oe), 0);
        bus_stop();
        read_run(8'hA1, 8'h05, 1);

        // R2 select bits are don't-care
        read_run(8'hAF, 8'h06, 1);

        // R4 address loaded then Stop instead of repeated Start
        set_addr(8'h80);
        bus_stop();
        read_run(8'hA1, 8'h80, 1);

        // R1 Start in the middle of a byte restarts reception
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        read_run(8'hA1, 8'h81, 1);

        // whole array in one stream, wrapping past 255
        set_addr(8'h00);
        read_run(8'hA1, 0, 257);
        read_run(8'hA1, 1, 1);

        // random read sweep over scattered addresses
        for (int i = 0; i < 16; i++) begin
            set_addr((i * 37 + 3) & 255);
            read_run(8'hA1, (i * 37 + 3) & 255, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule